// File: doc/BRIEF.md
# PIO Sector Relay Sequencer

This block sits between a host-side register interface and a disk drive and relays programmed-I/O data commands one sector at a time. Each sector is held in a store, passed once through a transform stage, and then forwarded. On a write the host fills the first buffer, the transform writes an enciphered copy into the second buffer, and that copy is streamed to the drive. On a read or an identify command the order is reversed: the drive fills the first buffer, the transform writes into the second, and the host drains it. An identify command passes its data through unchanged. The transform is a 16-bit XOR with a parameter key, so the same pass enciphers and deciphers.

A command starts with a one-cycle request that carries a command class. The sequencer then polls the drive status until the drive is no longer busy and copies that status into a result register. It also signals busy and interrupt to the host. Between sectors the drive's data-request bit decides whether another sector follows. An error or device-fault bit in any captured status ends the command at once.

Top module: `pio_sector_relay`

## Requirements
- R1: After reset hostBsy, hostIntrq, drvWrStb, bufOneEn and bufTwoEn are 0 and resultStatus is 0x00.
- R2: After a command is accepted, hostBsy is 1 and resultStatus keeps its value while drive status bit 7 (busy) is 1. On the first cycle with bit 7 at 0, resultStatus takes drvStatus.
- R3: For class 0 (write), a poll that sees bit 3 (data request) at 1 opens a host write window with hostBsy=0 and bufOneEn=1. Exactly WORDS hostWrStb strobes are taken, and after the last one hostBsy returns to 1.
- R4: After a block is filled, the transform runs for exactly WORDS cycles. On a write, drvWrStb is then 1 for WORDS consecutive cycles, and word i of the block, XORed with KEY, is presented in ascending order.
- R5: After a write block drains, the sequencer waits for drvIntrq. On drvIntrq it captures drvStatus into resultStatus and gives a one-cycle hostIntrq pulse. Then, if bit 3 is 1, it opens the next host write window; if bit 3 is 0, it returns to idle.
- R6: For class 1 (read), the drive fills the block with drvRdStb. After the transform, hostIntrq pulses once and hostBsy falls. The host reads word i XOR KEY on hostRdData, one word per hostRdStb, after which the drive is polled again.
- R7: Class 2 (identify) follows the read flow with bypassSel=1, and the host receives the drive's words unchanged.
- R8: If bit 0 (error) or bit 5 (device fault) is set in any captured status, hostIntrq pulses and the block returns to idle, whatever the value of bit 3.
- R9: hostWrStb outside a write window is ignored, and a class 3 request is ignored: it raises no busy and moves no data.
- R10: The word index wraps to 0 after word WORDS-1, so every later block again starts at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | One-cycle command request |
| cmdClass | input | 2 | 0 write, 1 read, 2 identify, 3 none |
| drvStatus | input | 8 | Drive status byte |
| drvIntrq | input | 1 | Drive interrupt |
| hostWrStb | input | 1 | Host word write strobe |
| hostWrData | input | 16 | Host write word |
| hostRdStb | input | 1 | Host word read strobe |
| hostRdData | output | 16 | Word offered to the host |
| drvRdStb | input | 1 | Drive word delivery strobe |
| drvRdData | input | 16 | Word from the drive |
| drvWrStb | output | 1 | Word to drive is valid |
| drvWrData | output | 16 | Word to the drive |
| hostBsy | output | 1 | Busy shown to the host |
| hostIntrq | output | 1 | Interrupt pulse to the host |
| resultStatus | output | 8 | Last captured drive status |
| bufOneEn | output | 1 | First buffer in use |
| bufTwoEn | output | 1 | Second buffer in use |
| bypassSel | output | 1 | Transform bypassed |

## Verification
A sequencer stuck in the wrong state first shows on hostBsy and the buffer enables, within one cycle of the edge that should have moved it. A word index that drifts or fails to wrap shows up as shifted or wrong words on drvWrData or hostRdData, and a second sector after the first exposes it. A wrong transform choice shows on the first drained word, because write and read data are compared against XOR-with-key and identify data against the raw words. Errors in the timing of the processing window show as a count of idle cycles before the drain that differs from WORDS.

// File: rtl/pio_relay_pkg.sv
package pio_relay_pkg;

  localparam int STAT_BSY = 7;
  localparam int STAT_DF  = 5;
  localparam int STAT_DRQ = 3;
  localparam int STAT_ERR = 0;

  typedef enum logic [1:0] {
    CLS_WRITE = 2'd0,
    CLS_READ  = 2'd1,
    CLS_IDENT = 2'd2,
    CLS_NONE  = 2'd3
  } cmdClass_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL,
    ST_HFILL,
    ST_DFILL,
    ST_PROC,
    ST_DRAIN,
    ST_WAITINT,
    ST_HDRAIN
  } relayState_e;

  typedef struct packed {
    logic oneWrHost;
    logic oneWrDrv;
    logic procWr;
    logic twoRdDrv;
    logic twoRdHost;
    logic bypass;
    logic capStatus;
  } relayStrb_t;

endpackage

// File: rtl/pio_relay_dp.sv
module pio_relay_dp
  import pio_relay_pkg::*;
#(
  parameter int WORDS = 256,
  parameter logic [15:0] KEY = 16'hA5C3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  relayStrb_t  strb,
  input  logic [15:0] hostWrData,
  input  logic [15:0] drvRdData,
  input  logic [7:0]  drvStatus,
  output logic [15:0] hostRdData,
  output logic [15:0] drvWrData,
  output logic [7:0]  resultStatus,
  output logic        lastWord
);

  localparam int IDXW = $clog2(WORDS);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(WORDS - 1);

  logic [15:0] bufOne [WORDS];
  logic [15:0] bufTwo [WORDS];
  logic [IDXW-1:0] wordIdx;
  logic moveAny;

  assign moveAny = strb.oneWrHost | strb.oneWrDrv | strb.procWr |
                   strb.twoRdDrv | strb.twoRdHost;
  assign lastWord = (wordIdx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wordIdx <= '0;
    end else if (moveAny) begin
      wordIdx <= lastWord ? '0 : wordIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.oneWrHost) begin
      bufOne[wordIdx] <= hostWrData;
    end else if (strb.oneWrDrv) begin
      bufOne[wordIdx] <= drvRdData;
    end
    if (strb.procWr) begin
      bufTwo[wordIdx] <= strb.bypass ? bufOne[wordIdx] : (bufOne[wordIdx] ^ KEY);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resultStatus <= 8'h00;
    end else if (strb.capStatus) begin
      resultStatus <= drvStatus;
    end
  end

  assign hostRdData = bufTwo[wordIdx];
  assign drvWrData  = bufTwo[wordIdx];

  // R10
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (moveAny && lastWord) |=> (wordIdx == '0));

  // R2
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.capStatus |=> $stable(resultStatus));

endmodule

// File: rtl/pio_relay_ctl.sv
module pio_relay_ctl
  import pio_relay_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmdValid,
  input  logic [1:0]  cmdClass,
  input  logic        drvBusy,
  input  logic        drvDrq,
  input  logic        drvFault,
  input  logic        drvIntrq,
  input  logic        hostWrStb,
  input  logic        hostRdStb,
  input  logic        drvRdStb,
  input  logic        lastWord,
  output relayStrb_t  strb,
  output logic        drvWrStb,
  output logic        hostBsy,
  output logic        hostIntrq,
  output logic        bufOneEn,
  output logic        bufTwoEn,
  output logic        bypassSel
);

  relayState_e state, stateNxt;
  logic isRead, isIdent;
  logic intrEvt;

  always_comb begin
    strb.oneWrHost = (state == ST_HFILL) && hostWrStb;
    strb.oneWrDrv  = (state == ST_DFILL) && drvRdStb;
    strb.procWr    = (state == ST_PROC);
    strb.twoRdDrv  = (state == ST_DRAIN);
    strb.twoRdHost = (state == ST_HDRAIN) && hostRdStb;
    strb.bypass    = isIdent;
    strb.capStatus = ((state == ST_POLL) && !drvBusy) ||
                     ((state == ST_WAITINT) && drvIntrq);
  end

  always_comb begin
    stateNxt = state;
    intrEvt  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cmdValid && (cmdClass != CLS_NONE)) stateNxt = ST_POLL;
      end
      ST_POLL: begin
        if (!drvBusy) begin
          if (drvFault) begin
            intrEvt  = 1'b1;
            stateNxt = ST_IDLE;
          end else if (drvDrq) begin
            stateNxt = isRead ? ST_DFILL : ST_HFILL;
          end else begin
            stateNxt = ST_IDLE;
          end
        end
      end
      ST_HFILL: begin
        if (strb.oneWrHost && lastWord) stateNxt = ST_PROC;
      end
      ST_DFILL: begin
        if (strb.oneWrDrv && lastWord) stateNxt = ST_PROC;
      end
      ST_PROC: begin
        if (lastWord) begin
          if (isRead) begin
            intrEvt  = 1'b1;
            stateNxt = ST_HDRAIN;
          end else begin
            stateNxt = ST_DRAIN;
          end
        end
      end
      ST_DRAIN: begin
        if (lastWord) stateNxt = ST_WAITINT;
      end
      ST_WAITINT: begin
        if (drvIntrq) begin
          intrEvt = 1'b1;
          if (!drvFault && drvDrq) stateNxt = ST_HFILL;
          else                     stateNxt = ST_IDLE;
        end
      end
      ST_HDRAIN: begin
        if (strb.twoRdHost && lastWord) stateNxt = ST_POLL;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      hostIntrq <= 1'b0;
      isRead    <= 1'b0;
      isIdent   <= 1'b0;
    end else begin
      state     <= stateNxt;
      hostIntrq <= intrEvt;
      if ((state == ST_IDLE) && cmdValid && (cmdClass != CLS_NONE)) begin
        isRead  <= (cmdClass == CLS_READ) || (cmdClass == CLS_IDENT);
        isIdent <= (cmdClass == CLS_IDENT);
      end
    end
  end

  assign hostBsy   = !((state == ST_IDLE) || (state == ST_HFILL) || (state == ST_HDRAIN));
  assign drvWrStb  = (state == ST_DRAIN);
  assign bufOneEn  = (state == ST_HFILL) || (state == ST_DFILL) || (state == ST_PROC);
  assign bufTwoEn  = (state == ST_PROC) || (state == ST_DRAIN) || (state == ST_HDRAIN);
  assign bypassSel = isIdent && (state != ST_IDLE);

  // R5
  intr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hostIntrq |=> !hostIntrq);

  // R4
  drain_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drvWrStb |-> hostBsy);

  // R8
  fault_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_WAITINT) && drvIntrq && drvFault) |=> (!bufOneEn && !hostBsy && hostIntrq));

  // R9
  none_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && !(cmdValid && (cmdClass != CLS_NONE))) |=> !hostBsy);

endmodule

// File: rtl/pio_sector_relay.sv
module pio_sector_relay
  import pio_relay_pkg::*;
#(
  parameter int WORDS = 256,
  parameter logic [15:0] KEY = 16'hA5C3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmdValid,
  input  logic [1:0]  cmdClass,
  input  logic [7:0]  drvStatus,
  input  logic        drvIntrq,
  input  logic        hostWrStb,
  input  logic [15:0] hostWrData,
  input  logic        hostRdStb,
  output logic [15:0] hostRdData,
  input  logic        drvRdStb,
  input  logic [15:0] drvRdData,
  output logic        drvWrStb,
  output logic [15:0] drvWrData,
  output logic        hostBsy,
  output logic        hostIntrq,
  output logic [7:0]  resultStatus,
  output logic        bufOneEn,
  output logic        bufTwoEn,
  output logic        bypassSel
);

  relayStrb_t strb;
  logic lastWord;

  pio_relay_ctl i_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmdValid  (cmdValid),
    .cmdClass  (cmdClass),
    .drvBusy   (drvStatus[STAT_BSY]),
    .drvDrq    (drvStatus[STAT_DRQ]),
    .drvFault  (drvStatus[STAT_ERR] | drvStatus[STAT_DF]),
    .drvIntrq  (drvIntrq),
    .hostWrStb (hostWrStb),
    .hostRdStb (hostRdStb),
    .drvRdStb  (drvRdStb),
    .lastWord  (lastWord),
    .strb      (strb),
    .drvWrStb  (drvWrStb),
    .hostBsy   (hostBsy),
    .hostIntrq (hostIntrq),
    .bufOneEn  (bufOneEn),
    .bufTwoEn  (bufTwoEn),
    .bypassSel (bypassSel)
  );

  pio_relay_dp #(.WORDS(WORDS), .KEY(KEY)) i_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strb         (strb),
    .hostWrData   (hostWrData),
    .drvRdData    (drvRdData),
    .drvStatus    (drvStatus),
    .hostRdData   (hostRdData),
    .drvWrData    (drvWrData),
    .resultStatus (resultStatus),
    .lastWord     (lastWord)
  );

endmodule

// File: tb/test_pio_sector_relay.sv
module test_pio_sector_relay;

  localparam int WORDS = 256;
  localparam logic [15:0] KEY = 16'hA5C3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdClass = 2'd0;
  logic [7:0] drvStatus = 8'h80;
  logic drvIntrq = 1'b0;
  logic hostWrStb = 1'b0;
  logic [15:0] hostWrData = 16'h0;
  logic hostRdStb = 1'b0;
  logic [15:0] hostRdData;
  logic drvRdStb = 1'b0;
  logic [15:0] drvRdData = 16'h0;
  logic drvWrStb;
  logic [15:0] drvWrData;
  logic hostBsy, hostIntrq, bufOneEn, bufTwoEn, bypassSel;
  logic [7:0] resultStatus;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pio_sector_relay #(.WORDS(WORDS), .KEY(KEY)) i_pio_sector_relay (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdClass(cmdClass),
    .drvStatus(drvStatus), .drvIntrq(drvIntrq), .hostWrStb(hostWrStb),
    .hostWrData(hostWrData), .hostRdStb(hostRdStb), .hostRdData(hostRdData),
    .drvRdStb(drvRdStb), .drvRdData(drvRdData), .drvWrStb(drvWrStb),
    .drvWrData(drvWrData), .hostBsy(hostBsy), .hostIntrq(hostIntrq),
    .resultStatus(resultStatus), .bufOneEn(bufOneEn), .bufTwoEn(bufTwoEn),
    .bypassSel(bypassSel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic startCmd(input logic [1:0] cls);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdClass = cls;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  // host fills one block, then the drained words are checked (R3, R4, R10)
  task automatic writeBlock(input logic [15:0] base);
    int gap;
    int errs;
    check("R3 window open", {30'd0, hostBsy, bufOneEn}, 32'h1);
    for (int i = 0; i < WORDS; i++) begin
      hostWrStb = 1'b1;
      hostWrData = base + 16'(i * 7);
      @(negedge clk);
    end
    hostWrStb = 1'b0;
    check("R3 busy after block", {31'd0, hostBsy}, 32'h1);
    gap = 0;
    while (!drvWrStb && gap < 4 * WORDS) begin
      gap++;
      @(negedge clk);
    end
    check("R4 processing cycles", gap, WORDS);
    errs = 0;
    for (int j = 0; j < WORDS; j++) begin
      if (!drvWrStb || drvWrData !== ((base + 16'(j * 7)) ^ KEY)) errs++;
      @(negedge clk);
    end
    check("R4 R10 drained words", errs, 0);
    check("R5 waits for drive", {30'd0, drvWrStb, hostBsy}, 32'h1);
  endtask

  task automatic driveIntr(input logic [7:0] st);
    drvStatus = st;
    drvIntrq = 1'b1;
    @(negedge clk);
    drvIntrq = 1'b0;
    check("R5 host interrupt", {31'd0, hostIntrq}, 32'h1);
    check("R5 status captured", resultStatus, st);
  endtask

  task automatic testReset();
    check("R1 reset outputs", {27'd0, hostBsy, hostIntrq, drvWrStb, bufOneEn, bufTwoEn}, 32'h0);
    check("R1 reset status", resultStatus, 8'h00);
  endtask

  task automatic testIgnored();
    drvStatus = 8'h08;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      hostWrStb = 1'b1;
      hostWrData = 16'hDEAD;
    end
    @(negedge clk);
    hostWrStb = 1'b0;
    startCmd(2'd3);
    @(negedge clk);
    check("R9 class 3 ignored", {30'd0, hostBsy, bufOneEn}, 32'h0);
    check("R9 status untouched", resultStatus, 8'h00);
  endtask

  task automatic testWrite();
    drvStatus = 8'h80;
    startCmd(2'd0);
    @(negedge clk);
    check("R2 busy while polling", {31'd0, hostBsy}, 32'h1);
    check("R2 status held", resultStatus, 8'h00);
    drvStatus = 8'h08;
    @(negedge clk);
    check("R2 status captured", resultStatus, 8'h08);
    writeBlock(16'h1000);
    driveIntr(8'h08);
    @(negedge clk);
    check("R5 pulse ends", {31'd0, hostIntrq}, 32'h0);
    writeBlock(16'h2345);
    driveIntr(8'h40);
    check("R5 back to idle", {30'd0, hostBsy, bufOneEn}, 32'h0);
    @(negedge clk);
  endtask

  task automatic testRead(input logic [1:0] cls, input logic [15:0] base);
    int errs;
    int wait_n;
    logic [15:0] expWord;
    drvStatus = 8'h08;
    startCmd(cls);
    @(negedge clk);
    drvStatus = 8'h80;
    check(cls == 2'd2 ? "R7 drive fill" : "R6 drive fill", {29'd0, hostBsy, bufOneEn, bypassSel},
          cls == 2'd2 ? 32'h7 : 32'h6);
    for (int i = 0; i < WORDS; i++) begin
      drvRdStb = 1'b1;
      drvRdData = base ^ 16'(i * 13);
      @(negedge clk);
    end
    drvRdStb = 1'b0;
    wait_n = 0;
    while (!hostIntrq && wait_n < 4 * WORDS) begin
      wait_n++;
      @(negedge clk);
    end
    check("R6 interrupt after transform", wait_n, WORDS);
    check("R6 host window", {30'd0, hostBsy, bufTwoEn}, 32'h1);
    errs = 0;
    for (int j = 0; j < WORDS; j++) begin
      expWord = (cls == 2'd2) ? (base ^ 16'(j * 13)) : (base ^ 16'(j * 13) ^ KEY);
      if (hostRdData !== expWord) errs++;
      hostRdStb = 1'b1;
      @(negedge clk);
    end
    hostRdStb = 1'b0;
    check(cls == 2'd2 ? "R7 identify data raw" : "R6 read data", errs, 0);
    check("R6 polls again", {31'd0, hostBsy}, 32'h1);
    drvStatus = 8'h00;
    @(negedge clk);
    check("R6 ends at idle", {29'd0, hostBsy, bufOneEn, hostIntrq}, 32'h0);
  endtask

  task automatic testFaults();
    drvStatus = 8'h09;
    startCmd(2'd0);
    @(negedge clk);
    check("R8 error at poll", {29'd0, hostIntrq, hostBsy, bufOneEn}, 32'h4);
    check("R8 error status", resultStatus, 8'h09);
    drvStatus = 8'h08;
    startCmd(2'd0);
    @(negedge clk);
    writeBlock(16'h0F0F);
    driveIntr(8'h28);
    check("R8 fault aborts", {30'd0, hostBsy, bufOneEn}, 32'h0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testIgnored();
    testWrite();
    testRead(2'd1, 16'h5A00);
    testRead(2'd2, 16'h1357);
    testFaults();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule